// File: doc/BRIEF.md
# Embedded Program and Erase Sequencer

This block carries out the internal work of a NOR-style flash model once a command sequence has been decoded upstream. It holds the array as a small register file of 16-bit words, all ones after power-up. A program operation writes one word, or one byte lane of a word, and can only clear bits. A chip erase first drives every word to zero in ascending order and then sets the whole array to ones. Program and erase times are counted in clock cycles, so the same logic can run with short delays in simulation and realistic ones elsewhere.

The host learns the state of an operation in two ways. The first is a ready output that drops for the whole operation. The second is status polling through the normal read port. While an operation runs, a read returns a status byte instead of array data. Bit 7 of that byte is a data-polling bit. Bit 6 and bit 2 are toggle bits. Bit 5 is a failure flag. If a program asks to raise a bit from 0 to 1, the block ends in a failure hold. In that state reads keep returning status with the failure flag set until a reset command clears it. A synchronous hard reset input aborts any running operation. After an abort, ready stays low for a recovery interval.

Top module: `nor_op_sequencer`

## Requirements
- R1: After rst_n is released, ready is 1, rd_data is 0, and every word reads 16'hFFFF in word mode (byte_mode = 0).
- R2: A program command (cmd_op = 1) accepted while idle keeps ready low for exactly PROG_CYCLES clock cycles. Each target bit becomes old AND new. The first read after ready rises returns array data.
- R3: cmd_addr and rd_addr are byte addresses. The word index is addr[ADDR_W:1] and the lane is addr[0]. With byte_mode = 1, lane 0 is bits [7:0] and lane 1 is bits [15:8]; the other lane is left unchanged. A byte-mode read returns the lane in [7:0] with [15:8] = 0.
- R4: A program that would raise any bit from 0 to 1 leaves that bit at 0 and ends in a failure hold. In the failure hold, ready is 1, reads return status with bit 5 = 1, and every command except reset (cmd_op = 3) is ignored. A reset command returns the block to array reads.
- R5: A chip erase (cmd_op = 2) keeps ready low for DEPTH*PROG_CYCLES + ERASE_CYCLES cycles. After it, every word is 16'hFFFF.
- R6: The erase preprogram zeroes word k at PROG_CYCLES*(k+1) cycles after acceptance, in ascending order. The array is filled with ones only after all words are zero, so an abort leaves exactly the words already visited at zero.
- R7: hard_rst high during an operation aborts it at once. Ready then stays low until RST_CYCLES cycles after the last cycle hard_rst is high. hard_rst while idle leaves ready at 1.
- R8: Commands arriving while an operation runs are ignored, including reset. They change neither the array nor the duration.
- R9: While busy, a read returns bit 7 = NOT bit 7 of the program data during a program, 0 during an erase, and bit 5 = 0.
- R10: Bit 6 inverts on every read while busy. Bit 2 inverts on every read during an erase but holds during a program. Bit 6 is frozen in the failure hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| hard_rst | input | 1 | Synchronous hardware reset, active high |
| byte_mode | input | 1 | 1 selects byte access for commands and reads |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 2 | 1 program, 2 chip erase, 3 reset, 0 none |
| cmd_addr | input | $clog2(DEPTH)+1 | Byte address of the program target |
| cmd_data | input | 16 | Program data (byte data in [7:0]) |
| rd_en | input | 1 | Read strobe; rd_data is updated on the next edge |
| rd_addr | input | $clog2(DEPTH)+1 | Byte address of the read |
| rd_data | output | 16 | Array data or status byte |
| ready | output | 1 | 1 when no operation or recovery is running |

## Verification
The bench targets an erase interrupted partway through the preprogram pass. A sequencer that zeroed words out of order, or that filled with ones too early, would leave the wrong words at zero. It also attempts to raise a cleared bit. A design that wrote the new value, or that dropped the failure flag on the next command, would return the wrong word or array data in place of status. Program and reset commands are issued during busy periods; a design that obeyed them would corrupt another word or shorten the erase. The bench also compares pairs of back-to-back status reads, which catch a toggle bit that is frozen, or that moves during a program when it should hold.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
   localparam int WORD_W = 16;

   typedef enum logic [2:0] {
      ST_READ, ST_PROG, ST_PRE, ST_ERASE, ST_FAIL, ST_RECOVER
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_RESET = 2'd3
   } seq_op_t;

   function automatic logic seq_busy(input seq_state_t s);
      return (s == ST_PROG) || (s == ST_PRE) || (s == ST_ERASE);
   endfunction
endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/nor_seq_array.sv
module nor_seq_array
   import nor_seq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_idx,
   input  logic [WORD_W-1:0]         wr_keep,
   input  logic                      fill_en,
   output logic [DEPTH*WORD_W-1:0]   words
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [WORD_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '1;
         else if (fill_en)
            cell_q <= '1;
         else if (wr_en && (wr_idx == ADDR_W'(i)))
            cell_q <= cell_q & wr_keep;
      end
      assign words[i*WORD_W +: WORD_W] = cell_q;
   end
endmodule

// File: rtl/nor_seq_status.sv
module nor_seq_status
   import nor_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              busy_op,
   input  logic              erasing,
   input  logic              fail,
   input  logic              poll_bit,
   output logic [WORD_W-1:0] stat,
   output logic              tog6
);
   logic tog2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog6   <= 1'b0;
         tog2_q <= 1'b0;
      end else if (rd_en) begin
         if (busy_op) tog6   <= ~tog6;
         if (erasing) tog2_q <= ~tog2_q;
      end
   end

   assign stat = {8'h00, poll_bit, tog6, fail, 2'b00, tog2_q, 2'b00};
endmodule

// File: rtl/nor_op_sequencer.sv
module nor_op_sequencer
   import nor_seq_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 32,
   parameter int RST_CYCLES   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hard_rst,
   input  logic                     byte_mode,
   input  logic                     cmd_valid,
   input  logic [1:0]               cmd_op,
   input  logic [$clog2(DEPTH):0]   cmd_addr,
   input  logic [15:0]              cmd_data,
   input  logic                     rd_en,
   input  logic [$clog2(DEPTH):0]   rd_addr,
   output logic [15:0]              rd_data,
   output logic                     ready
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int TMAX_A = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int TMAX   = (TMAX_A > RST_CYCLES) ? TMAX_A : RST_CYCLES;
   localparam int TW     = $clog2(TMAX + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1 || RST_CYCLES < 1) begin : g_bad_cycles
      $error("cycle counts must be at least 1");
   end

   seq_state_t              st_q;
   seq_op_t                 op;
   logic [ADDR_W-1:0]       lat_idx, ptr_q;
   logic                    lat_lane, lat_byte;
   logic [WORD_W-1:0]       lat_data;
   logic [DEPTH*WORD_W-1:0] words;
   logic                    tmr_zero, tmr_load;
   logic [TW-1:0]           tmr_val;
   logic                    busy_op, erasing, ptr_last;
   logic [WORD_W-1:0]       pmask, pval, old_word, arr_keep, rd_word, arr_out, stat;
   logic                    fail_hit, arr_wr, arr_fill, poll_bit, tog6;
   logic [ADDR_W-1:0]       arr_idx, rd_idx;

   assign op       = seq_op_t'(cmd_op);
   assign busy_op  = seq_busy(st_q);
   assign erasing  = (st_q == ST_PRE) || (st_q == ST_ERASE);
   assign ptr_last = (ptr_q == ADDR_W'(DEPTH - 1));
   assign ready    = !(busy_op || st_q == ST_RECOVER);

   // Lane selection for the latched program request
   always_comb begin
      if (!lat_byte) begin
         pmask = 16'hFFFF;
         pval  = lat_data;
      end else if (lat_lane) begin
         pmask = 16'hFF00;
         pval  = {lat_data[7:0], 8'h00};
      end else begin
         pmask = 16'h00FF;
         pval  = {8'h00, lat_data[7:0]};
      end
   end

   assign old_word = words[lat_idx*WORD_W +: WORD_W];
   assign fail_hit = |(pmask & pval & ~old_word);

   // Timer reload decisions
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (hard_rst) begin
         if (busy_op || st_q == ST_RECOVER) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYCLES - 1);
         end
      end else begin
         case (st_q)
            ST_READ: if (cmd_valid && (op == OP_PROG || op == OP_ERASE)) begin
               tmr_load = 1'b1;
               tmr_val  = TW'(PROG_CYCLES - 1);
            end
            ST_PRE: if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = ptr_last ? TW'(ERASE_CYCLES - 1) : TW'(PROG_CYCLES - 1);
            end
            default: ;
         endcase
      end
   end

   nor_seq_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   // Operation sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_READ;
         lat_idx  <= '0;
         lat_lane <= 1'b0;
         lat_byte <= 1'b0;
         lat_data <= '0;
         ptr_q    <= '0;
      end else if (hard_rst) begin
         st_q <= (busy_op || st_q == ST_RECOVER) ? ST_RECOVER : ST_READ;
      end else begin
         case (st_q)
            ST_READ: if (cmd_valid) begin
               if (op == OP_PROG) begin
                  st_q     <= ST_PROG;
                  lat_idx  <= cmd_addr[ADDR_W:1];
                  lat_lane <= cmd_addr[0];
                  lat_byte <= byte_mode;
                  lat_data <= cmd_data;
               end else if (op == OP_ERASE) begin
                  st_q  <= ST_PRE;
                  ptr_q <= '0;
               end
            end
            ST_PROG:    if (tmr_zero) st_q <= fail_hit ? ST_FAIL : ST_READ;
            ST_PRE:     if (tmr_zero) begin
               if (ptr_last) st_q <= ST_ERASE;
               else          ptr_q <= ptr_q + 1'b1;
            end
            ST_ERASE:   if (tmr_zero) st_q <= ST_READ;
            ST_FAIL:    if (cmd_valid && op == OP_RESET) st_q <= ST_READ;
            ST_RECOVER: if (tmr_zero) st_q <= ST_READ;
            default:    st_q <= ST_READ;
         endcase
      end
   end

   assign arr_wr   = !hard_rst && tmr_zero && (st_q == ST_PROG || st_q == ST_PRE);
   assign arr_idx  = (st_q == ST_PROG) ? lat_idx : ptr_q;
   assign arr_keep = (st_q == ST_PROG) ? (pval | ~pmask) : '0;
   assign arr_fill = !hard_rst && tmr_zero && (st_q == ST_ERASE);

   nor_seq_array #(.DEPTH(DEPTH)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (arr_wr),
      .wr_idx  (arr_idx),
      .wr_keep (arr_keep),
      .fill_en (arr_fill),
      .words   (words)
   );

   assign poll_bit = erasing ? 1'b0 : ~lat_data[7];

   nor_seq_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .busy_op  (busy_op),
      .erasing  (erasing),
      .fail     (st_q == ST_FAIL),
      .poll_bit (poll_bit),
      .stat     (stat),
      .tog6     (tog6)
   );

   // Read path
   assign rd_idx  = rd_addr[ADDR_W:1];
   assign rd_word = words[rd_idx*WORD_W +: WORD_W];
   assign arr_out = byte_mode ? {8'h00, (rd_addr[0] ? rd_word[15:8] : rd_word[7:0])} : rd_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= (busy_op || st_q == ST_FAIL) ? stat : arr_out;
   end
endmodule

// File: rtl/nor_seq_checker.sv
module nor_seq_checker
   import nor_seq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    hard_rst,
   input logic                    cmd_valid,
   input logic [1:0]              cmd_op,
   input logic                    rd_en,
   input logic                    ready,
   input seq_state_t              st,
   input logic                    tmr_zero,
   input logic [ADDR_W-1:0]       lat_idx,
   input logic                    tog6,
   input logic [DEPTH*WORD_W-1:0] words
);
   AST_PROG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PROG) |=> ((words & ~$past(words)) == '0)); // R2

   AST_PRE_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE) |-> (words == '0)); // R6

   AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERASE && tmr_zero && !hard_rst) |=> (&words)); // R5

   AST_ABORT_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_rst && seq_busy(st)) |=> (st == ST_RECOVER && !ready)); // R7

   AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy(st) && cmd_valid && !hard_rst) |=> $stable(lat_idx)); // R8

   AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && seq_busy(st)) |=> (tog6 != $past(tog6))); // R10

   AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FAIL && !hard_rst && !(cmd_valid && cmd_op == 2'd3)) |=> (st == ST_FAIL && ready)); // R4
endmodule

bind nor_op_sequencer nor_seq_checker #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hard_rst  (hard_rst),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .rd_en     (rd_en),
   .ready     (ready),
   .st        (st_q),
   .tmr_zero  (tmr_zero),
   .lat_idx   (lat_idx),
   .tog6      (tog6),
   .words     (words)
);

// File: tb/nor_op_sequencer_tb.sv
module nor_op_sequencer_tb;
   localparam int DEPTH = 8;
   localparam int PC    = 4;
   localparam int EC    = 6;
   localparam int RC    = 3;
   localparam int NVEC  = 6;

   // entry: {byte address[3:0], data[15:0], byte_mode}
   localparam logic [20:0] VEC [NVEC] = '{
      {4'h0, 16'hA5F0, 1'b0},
      {4'h2, 16'h1234, 1'b0},
      {4'h5, 16'h003C, 1'b1},
      {4'h6, 16'h0081, 1'b1},
      {4'h0, 16'h2570, 1'b0},
      {4'hA, 16'h0000, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, hard_rst = 1'b0, byte_mode = 1'b0;
   logic cmd_valid = 1'b0, rd_en = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [3:0]  cmd_addr = '0, rd_addr = '0;
   logic [15:0] cmd_data = '0;
   logic [15:0] rd_data;
   logic        ready;

   int nchk = 0, nfail = 0, busy_cnt = 0;
   logic [15:0] mdl [DEPTH];

   always #2.5 clk = ~clk;

   nor_op_sequencer #(.DEPTH(DEPTH), .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .RST_CYCLES(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .byte_mode(byte_mode),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready)
   );

   always @(negedge clk) if (!ready) busy_cnt++;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [3:0] a, input logic [15:0] d, input logic bm);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; byte_mode = bm;
      @(negedge clk);
      cmd_valid = 1'b0; byte_mode = 1'b0;
   endtask

   task automatic wait_ready();
      int n = 0;
      while (!ready && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rd(input logic [3:0] a, input logic bm, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; byte_mode = bm;
      @(negedge clk);
      rd_en = 1'b0; byte_mode = 1'b0;
      d = rd_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      logic [15:0] d, s1, s2, msk, val;
      for (int i = 0; i < DEPTH; i++) mdl[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ready", {15'd0, ready}, 16'd1);
      chk("R1 rd_data", rd_data, 16'h0000);
      rd(4'h0, 1'b0, d); chk("R1 word0", d, 16'hFFFF);
      rd(4'hE, 1'b0, d); chk("R1 word7", d, 16'hFFFF);

      // R2/R3 vector table
      for (int v = 0; v < NVEC; v++) begin
         logic [3:0]  a;
         logic [15:0] dat;
         logic        bm;
         {a, dat, bm} = VEC[v];
         busy_cnt = 0;
         do_cmd(2'd1, a, dat, bm);
         wait_ready();
         chk("R2 program duration", 16'(busy_cnt), 16'(PC));
         if (!bm) begin msk = 16'hFFFF; val = dat; end
         else if (a[0]) begin msk = 16'hFF00; val = {dat[7:0], 8'h00}; end
         else begin msk = 16'h00FF; val = {8'h00, dat[7:0]}; end
         mdl[a[3:1]] = mdl[a[3:1]] & (val | ~msk);
         rd({a[3:1], 1'b0}, 1'b0, d);
         chk(bm ? "R3 byte program word" : "R2 program word", d, mdl[a[3:1]]);
         if (bm) begin
            rd(a, 1'b1, d);
            chk("R3 byte read lane", d, {8'h00, a[0] ? mdl[a[3:1]][15:8] : mdl[a[3:1]][7:0]});
         end
      end

      // R9/R10 status during program of word3 (FF81 -> 0001)
      do_cmd(2'd1, 4'h6, 16'h0001, 1'b0);
      rd_en = 1'b1; rd_addr = 4'h6;
      @(negedge clk); s1 = rd_data;
      @(negedge clk); s2 = rd_data;
      rd_en = 1'b0;
      chk("R9 program poll bit7", {15'd0, s1[7]}, 16'd1);
      chk("R9 busy bit5", {15'd0, s1[5]}, 16'd0);
      chk("R10 bit6 toggles in program", {15'd0, s1[6] ^ s2[6]}, 16'd1);
      chk("R10 bit2 holds in program", {15'd0, s1[2] ^ s2[2]}, 16'd0);
      wait_ready();
      rd(4'h6, 1'b0, d); chk("R2 array data after completion", d, 16'h0001);

      // R8 program command during busy ignored
      busy_cnt = 0;
      do_cmd(2'd1, 4'h8, 16'h00F0, 1'b0);
      do_cmd(2'd1, 4'hE, 16'h0000, 1'b0);
      wait_ready();
      chk("R8 duration unchanged", 16'(busy_cnt), 16'(PC));
      rd(4'hE, 1'b0, d); chk("R8 ignored program", d, 16'hFFFF);
      rd(4'h8, 1'b0, d); chk("R2 word4", d, 16'h00F0);

      // R4 failure on 0->1 attempt, word1 = 1234
      do_cmd(2'd1, 4'h2, 16'h1235, 1'b0);
      wait_ready();
      chk("R4 ready in failure hold", {15'd0, ready}, 16'd1);
      rd(4'h2, 1'b0, s1);
      rd(4'h2, 1'b0, s2);
      chk("R4 fail bit5", {15'd0, s1[5]}, 16'd1);
      chk("R4 fail poll bit7", {15'd0, s1[7]}, 16'd1);
      chk("R10 bit6 frozen in failure", {15'd0, s1[6] ^ s2[6]}, 16'd0);
      do_cmd(2'd1, 4'hE, 16'h0000, 1'b0);
      rd(4'h2, 1'b0, d); chk("R4 still failing after program cmd", {15'd0, d[5]}, 16'd1);
      do_cmd(2'd3, 4'h0, 16'h00F0, 1'b0);
      rd(4'h2, 1'b0, d); chk("R4 bit stays 0", d, 16'h1234);
      rd(4'hE, 1'b0, d); chk("R4 program ignored in hold", d, 16'hFFFF);

      // R5/R9/R10/R8 chip erase
      busy_cnt = 0;
      do_cmd(2'd2, 4'h0, 16'h0000, 1'b0);
      rd_en = 1'b1; rd_addr = 4'h0;
      @(negedge clk); s1 = rd_data;
      @(negedge clk); s2 = rd_data;
      rd_en = 1'b0;
      chk("R9 erase poll bit7", {15'd0, s1[7]}, 16'd0);
      chk("R10 bit2 toggles in erase", {15'd0, s1[2] ^ s2[2]}, 16'd1);
      chk("R10 bit6 toggles in erase", {15'd0, s1[6] ^ s2[6]}, 16'd1);
      do_cmd(2'd3, 4'h0, 16'h0000, 1'b0);
      wait_ready();
      chk("R5 erase duration", 16'(busy_cnt), 16'(DEPTH * PC + EC));
      for (int i = 0; i < DEPTH; i++) begin
         rd(4'(2 * i), 1'b0, d); chk("R5 erased word", d, 16'hFFFF);
      end

      // R6/R7 abort during preprogram at cycle 2*PC+1
      busy_cnt = 0;
      do_cmd(2'd2, 4'h0, 16'h0000, 1'b0);
      repeat (2 * PC) @(negedge clk);
      hard_rst = 1'b1;
      @(negedge clk);
      hard_rst = 1'b0;
      wait_ready();
      chk("R7 abort plus recovery", 16'(busy_cnt), 16'(2 * PC + 1 + RC));
      rd(4'h0, 1'b0, d); chk("R6 word0 zeroed", d, 16'h0000);
      rd(4'h2, 1'b0, d); chk("R6 word1 zeroed", d, 16'h0000);
      rd(4'h4, 1'b0, d); chk("R6 word2 untouched", d, 16'hFFFF);
      rd(4'hE, 1'b0, d); chk("R6 word7 untouched", d, 16'hFFFF);

      // R6/R7 abort in erase phase
      busy_cnt = 0;
      do_cmd(2'd2, 4'h0, 16'h0000, 1'b0);
      repeat (DEPTH * PC + 1) @(negedge clk);
      hard_rst = 1'b1;
      @(negedge clk);
      hard_rst = 1'b0;
      wait_ready();
      chk("R7 abort in erase phase", 16'(busy_cnt), 16'(DEPTH * PC + 2 + RC));
      rd(4'hE, 1'b0, d); chk("R6 no fill before abort", d, 16'h0000);
      rd(4'h6, 1'b0, d); chk("R6 word3 zero", d, 16'h0000);

      // R7 hard reset while idle
      @(negedge clk); hard_rst = 1'b1;
      @(negedge clk); chk("R7 idle reset ready", {15'd0, ready}, 16'd1);
      hard_rst = 1'b0;
      @(negedge clk); chk("R7 idle reset ready after", {15'd0, ready}, 16'd1);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule